// File: doc/BRIEF.md
# Interval Timer with Three Byte Ports

This block is a small memory-mapped peripheral. It holds three independent 8-bit ports and an 8-bit programmable interval timer, all in one eight-byte register window at the top of a 16-bit address space. Each port has an output register that software can write and read back, and an input register that only samples the pins. No direction register exists: the output and input sides are always separate.

The timer has a reload latch and a down-counter. A prescaler divides the system clock by 2, 4, 8 or 16 to make the count ticks. In one-shot mode the timer counts down once and stops at zero. It drives a low pulse on port C bit 7 whose width is the programmed count. In free-run mode it reloads from the latch at every expiry and toggles that bit, which gives a square wave. A sticky expired flag records each expiry. Reading the flag clears it.

The bus is a simple byte-wide strobe interface. Writes take effect at the clock edge. Read data is combinational from the address, and the read strobe only matters for the clear-on-read side effect.

Top module: `tmr_ioport`

## Requirements
- R1: After reset, all port output registers, the counter, the latch and the expired flag are zero. The timer is stopped, in one-shot mode, with prescale f/2 and the port C bit 7 override off. The internal timer waveform is high.
- R2: The window uses fixed byte addresses. 0xFFF8, 0xFFFA and 0xFFFC hold the port A, B and C output registers (write and read). 0xFFF9, 0xFFFB and 0xFFFD hold the port A, B and C input registers (read only). 0xFFFE is the timer value. 0xFFFF is the flag on reads and the control register on writes. Any address outside the window reads as zero.
- R3: A write to an input-register address changes no output register.
- R4: A write to 0xFFFE loads the byte into both the latch and the counter. It clears the expired flag, drives the timer waveform low and restarts the prescaler. A read of 0xFFFE returns the current counter.
- R5: The control byte has these fields: bit 0 run, bit 1 mode (0 one-shot, 1 free-run), bits 3:2 prescale (00 f/2, 01 f/4, 10 f/8, 11 f/16), bit 4 pin override enable. The counter drops by one every D clocks while run is set. Expiry therefore comes L×D clock edges after the edge that sets run, where L is the loaded count.
- R6: In one-shot mode, the tick that takes the counter from 1 to 0 sets the flag and drives the waveform high. The counter then stays at 0 and is not reloaded.
- R7: In free-run mode, the tick at which the counter would reach zero sets the flag, toggles the waveform and reloads the counter from the latch.
- R8: The flag reads as bit 0 of 0xFFFF, with bits 7:1 zero. Once set, it stays set until a read strobe at 0xFFFF or a write to 0xFFFE. If an expiry and a clearing read fall in the same cycle, the flag stays set.
- R9: While run is clear, the counter holds its value.
- R10: While the override is enabled, port C pin bit 7 carries the timer waveform instead of the register bit. A read of 0xFFFC always returns the register itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the flag at 0xFFFF) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pa_in | input | 8 | Port A pins in |
| pb_in | input | 8 | Port B pins in |
| pc_in | input | 8 | Port C pins in |
| pa_out | output | 8 | Port A pins out |
| pb_out | output | 8 | Port B pins out |
| pc_out | output | 8 | Port C pins out, bit 7 optionally the timer waveform |

## Verification
The properties assume that the bus asserts at most one strobe per cycle and that the write data is stable while the write strobe is high. The bench keeps to this by raising one strobe at a time, on the falling edge, for exactly one cycle. The flag properties treat a cycle with both an expiry and a clearing read as one where the set wins. The bench only issues clearing reads while the counter is stopped or already expired in one-shot mode, so it never hits that coincidence by accident.

// File: rtl/tmr_ioport.sv
module tmr_ioport #(
  parameter int W = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = 16'hFFF8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pa_in,
  input  logic [W-1:0]  pb_in,
  input  logic [W-1:0]  pc_in,
  output logic [W-1:0]  pa_out,
  output logic [W-1:0]  pb_out,
  output logic [W-1:0]  pc_out
);
  localparam int PW = 4;

  logic [W-1:0] pa_q, pb_q, pc_q, cnt, latch;
  logic [PW-1:0] pre, pmask;
  logic [1:0] sel;
  logic run, fr, oe, flag, wave;
  logic hit, we, val_wr, ctl_wr, flag_rd, tick, expire;
  logic [2:0] off;

  assign hit     = bus_addr[AW-1:3] == BASE[AW-1:3];
  assign off     = bus_addr[2:0];
  assign we      = bus_wr && hit;
  assign val_wr  = we && off == 3'd6;
  assign ctl_wr  = we && off == 3'd7;
  assign flag_rd = bus_rd && hit && off == 3'd7;

  always_comb begin
    case (sel)
      2'd0: pmask = 4'd1;
      2'd1: pmask = 4'd3;
      2'd2: pmask = 4'd7;
      default: pmask = 4'd15;
    endcase
  end

  assign tick   = run && ((pre & pmask) == pmask);
  assign expire = tick && !val_wr &&
                  (fr ? (cnt <= W'(1)) : (cnt == W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_q <= '0;
      pb_q <= '0;
      pc_q <= '0;
    end else if (we) begin
      case (off)
        3'd0: pa_q <= bus_wdata;
        3'd2: pb_q <= bus_wdata;
        3'd4: pc_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      fr  <= 1'b0;
      sel <= 2'd0;
      oe  <= 1'b0;
    end else if (ctl_wr) begin
      run <= bus_wdata[0];
      fr  <= bus_wdata[1];
      sel <= bus_wdata[3:2];
      oe  <= bus_wdata[4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run || val_wr) pre <= '0;
    else pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      latch <= '0;
    end else if (val_wr) begin
      cnt   <= bus_wdata;
      latch <= bus_wdata;
    end else if (tick) begin
      if (fr) cnt <= (cnt <= W'(1)) ? latch : cnt - 1'b1;
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wave <= 1'b1;
    else if (val_wr) wave <= 1'b0;
    else if (expire) wave <= fr ? ~wave : 1'b1;
    else if (tick && !fr && cnt == latch && cnt != '0) wave <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else if (expire) flag <= 1'b1;
    else if (val_wr || flag_rd) flag <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (off)
        3'd0: bus_rdata = pa_q;
        3'd1: bus_rdata = pa_in;
        3'd2: bus_rdata = pb_q;
        3'd3: bus_rdata = pb_in;
        3'd4: bus_rdata = pc_q;
        3'd5: bus_rdata = pc_in;
        3'd6: bus_rdata = cnt;
        default: bus_rdata = {{(W-1){1'b0}}, flag};
      endcase
    end
  end

  assign pa_out = pa_q;
  assign pb_out = pb_q;
  assign pc_out = oe ? {wave, pc_q[W-2:0]} : pc_q;
endmodule

// File: rtl/tmr_ioport_chk.sv
module tmr_ioport_chk #(
  parameter int W = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = 16'hFFF8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  pa_out,
  input logic [W-1:0]  cnt,
  input logic          run,
  input logic          fr,
  input logic          flag,
  input logic          wave,
  input logic          expire
);
  logic ld, clr;
  assign ld  = bus_wr && bus_addr == (BASE + AW'(6));
  assign clr = bus_rd && bus_addr == (BASE + AW'(7));

  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !ld |=> $stable(cnt));
  // R8
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr && !ld |=> flag);
  // R8
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !expire |=> !flag);
  // R3
  in_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == (BASE + AW'(1)) |=> $stable(pa_out));
  // R6
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fr && cnt == '0 && !ld |=> cnt == '0);
  // R7
  fr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr && expire |=> wave != $past(wave));
  // R4
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(bus_wdata) && !flag && !wave);
endmodule

bind tmr_ioport tmr_ioport_chk #(.W(W), .AW(AW), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .pa_out(pa_out), .cnt(cnt),
  .run(run), .fr(fr), .flag(flag), .wave(wave), .expire(expire));

// File: tb/sim_tmr_ioport.sv
`timescale 1ns/100ps
module sim_tmr_ioport;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] bus_rdata, pa_out, pb_out, pc_out;
  int errs = 0, nchk = 0;

  always #2 clk = ~clk;

  tmr_ioport u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pa_in(pa_in),
    .pb_in(pb_in), .pc_in(pc_in), .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out));

  // {prescale select, count}
  localparam logic [9:0] VEC [5] = '{
    {2'd0, 8'd3}, {2'd1, 8'd2}, {2'd2, 8'd5}, {2'd3, 8'd1}, {2'd1, 8'd7}};

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #0.5;
    bus_wr = 0;
  endtask

  task automatic rdc(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #0.5 d = bus_rdata;
    @(posedge clk); #0.5;
    bus_rd = 0;
  endtask

  task automatic peek(logic [15:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #0.5;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    edges(3);
    rst_n = 1;
    edges(1);
    // R1 reset state
    chk("R1 pa_out", pa_out, 8'h00);
    chk("R1 pc_out", pc_out, 8'h00);
    peek(16'hFFFE, v); chk("R1 counter", v, 8'h00);
    peek(16'hFFFF, v); chk("R1 flag", v, 8'h00);

    // R2 port map
    wr(16'hFFF8, 8'hA5); wr(16'hFFFA, 8'h5A); wr(16'hFFFC, 8'h7F);
    pa_in = 8'h3C; pb_in = 8'hC3; pc_in = 8'h99;
    chk("R2 pa pin", pa_out, 8'hA5);
    chk("R2 pb pin", pb_out, 8'h5A);
    peek(16'hFFF8, v); chk("R2 pa reg", v, 8'hA5);
    peek(16'hFFFA, v); chk("R2 pb reg", v, 8'h5A);
    peek(16'hFFFC, v); chk("R2 pc reg", v, 8'h7F);
    peek(16'hFFF9, v); chk("R2 pa in", v, 8'h3C);
    peek(16'hFFFB, v); chk("R2 pb in", v, 8'hC3);
    peek(16'hFFFD, v); chk("R2 pc in", v, 8'h99);
    peek(16'h1234, v); chk("R2 outside", v, 8'h00);

    // R3 input addresses are read only
    wr(16'hFFF9, 8'h11); wr(16'hFFFB, 8'h22); wr(16'hFFFD, 8'h33);
    chk("R3 pa", pa_out, 8'hA5);
    chk("R3 pb", pb_out, 8'h5A);
    chk("R3 pc", pc_out, 8'h7F);

    // R10 override off then on (wave high from reset)
    wr(16'hFFFF, 8'h10);
    chk("R10 pin wave", pc_out, 8'hFF);
    peek(16'hFFFC, v); chk("R10 reg read", v, 8'h7F);

    // R5 R6 one-shot vectors
    for (int i = 0; i < 5; i++) begin
      logic [1:0] s; logic [7:0] l; int d;
      s = VEC[i][9:8]; l = VEC[i][7:0]; d = 2 << s;
      wr(16'hFFFF, {3'b000, 1'b1, s, 1'b0, 1'b0});
      wr(16'hFFFE, l);
      chk("R4 wave low after load", {7'd0, pc_out[7]}, 8'd0);
      peek(16'hFFFE, v); chk("R4 counter loaded", v, l);
      wr(16'hFFFF, {3'b000, 1'b1, s, 1'b0, 1'b1});
      edges(l * d - 1);
      peek(16'hFFFF, v); chk("R5 flag before expiry", v, 8'h00);
      edges(1);
      peek(16'hFFFF, v); chk("R5 flag at expiry", v, 8'h01);
      chk("R6 pin high", {7'd0, pc_out[7]}, 8'd1);
      edges(2 * d);
      peek(16'hFFFE, v); chk("R6 no reload", v, 8'h00);
      peek(16'hFFFF, v); chk("R8 sticky", v, 8'h01);
      rdc(16'hFFFF, v); chk("R8 read value", v, 8'h01);
      peek(16'hFFFF, v); chk("R8 cleared by read", v, 8'h00);
    end

    // R7 free-run, count 2, f/2
    wr(16'hFFFF, 8'h12);
    wr(16'hFFFE, 8'd2);
    wr(16'hFFFF, 8'h13);
    edges(3);
    peek(16'hFFFE, v); chk("R7 mid count", v, 8'd1);
    peek(16'hFFFF, v); chk("R7 no flag yet", v, 8'h00);
    edges(1);
    peek(16'hFFFE, v); chk("R7 reload", v, 8'd2);
    peek(16'hFFFF, v); chk("R7 flag", v, 8'h01);
    chk("R7 toggle high", {7'd0, pc_out[7]}, 8'd1);
    edges(4);
    chk("R7 toggle low", {7'd0, pc_out[7]}, 8'd0);
    peek(16'hFFFF, v); chk("R8 sticky free-run", v, 8'h01);

    // R9 stop holds; R8 cleared by value write
    wr(16'hFFFF, 8'h12);
    wr(16'hFFFE, 8'd5);
    peek(16'hFFFF, v); chk("R8 cleared by load", v, 8'h00);
    wr(16'hFFFF, 8'h13);
    edges(3);
    wr(16'hFFFF, 8'h12);
    edges(20);
    peek(16'hFFFE, v); chk("R9 held count", v, 8'd3);

    // R10 override off gives register bit back
    wr(16'hFFFF, 8'h00);
    chk("R10 override off", pc_out, 8'h7F);

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule